// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Updates

This block drives one pulse-width modulated line per channel from a shared register bus. Each channel divides the input clock into counter steps with an 8-bit prescaler. It counts steps up to an 8-bit period modulus, and it holds its line high for the first part of each period, as set by a 16-bit duty value. Software programs a channel by writing its registers through a simple single-cycle write/read bus. The channel index and the register are selected by the address.

Prescaler, modulus and duty writes land in shadow copies. The duty write is the trigger. It arms one commit that moves all three shadow values into the active set together. While a channel runs, that commit waits for the end of the current period, so a period never mixes old and new settings. Clearing the enable bit is not deferred: the line drops on the clock edge that takes the write.

Top module: `mpwm_top`

## Requirements
- R1: Channel c owns the address window starting at c·32. Within it, offset 0x00 holds the prescaler (bits 7:0), 0x04 the modulus (bits 7:0), 0x08 the duty (bits 15:0) and 0x18 the enable (bit 0). A read returns the last value written, masked to its field, on `bus_rdata` after the clock edge that samples `bus_rd`.
- R2: A read of any other offset returns zero, and a write to one changes no register and no output.
- R3: While enabled, a counter step lasts prescaler+1 clocks and a period lasts max(modulus,1) steps. The line is high for the first duty steps of the period and low for the rest.
- R4: A duty greater than or equal to the modulus keeps the line high for the whole period. A duty of zero keeps it low.
- R5: A write to the prescaler or the modulus alone leaves the running waveform unchanged.
- R6: A duty write commits the shadow prescaler, modulus and duty together. On a running channel the current period finishes with the old values, and the new ones start at the next period boundary.
- R7: On a disabled channel a pending commit is applied at once. Setting enable from 0 to 1 restarts the counters, and the line shows step 0 of a new period on the edge that takes the write.
- R8: Writing 0 to the enable bit drives the line low on the edge that takes the write, even in the middle of a period. A disabled channel drives its line low.
- R9: After reset every register reads zero and every line is low.
- R10: Register access to one channel does not change another channel's registers or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW (7) | Byte address: channel in the upper bits, offset in bits 4:0 |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pwm_o | output | NCH (4) | One modulated line per channel |

## Verification
The bench first updates the modulus alone on a running channel and counts high cycles over a window. A design that applied the modulus early would halve that count. It then writes the duty mid-period and checks that the old tail contains no extra high time and that the first new period has exactly the new shape. A design that committed at once would give a truncated or stretched first high run. Clearing enable is checked on the very next sample while the line is high, which catches a design that waits for the period to end. Out-of-range duty, zero duty, zero modulus and prescaled vectors are checked cycle by cycle from the restart point, which catches off-by-one step counting and a design that fails to restart on enable.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRE,
    RK_MOD,
    RK_DUTY,
    RK_EN
  } reg_kind_e;

  localparam int WIN_BITS = 5;
  localparam logic [WIN_BITS-1:0] OFS_PRE  = 5'h00;
  localparam logic [WIN_BITS-1:0] OFS_MOD  = 5'h04;
  localparam logic [WIN_BITS-1:0] OFS_DUTY = 5'h08;
  localparam logic [WIN_BITS-1:0] OFS_EN   = 5'h18;

endpackage

// File: rtl/mpwm_decode.sv
module mpwm_decode
  import mpwm_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHB + WIN_BITS
)(
  input  logic [AW-1:0]  addr,
  output logic [CHB-1:0] chan,
  output reg_kind_e      kind
);

  logic [WIN_BITS-1:0] ofs;

  assign ofs  = addr[WIN_BITS-1:0];
  assign chan = addr[AW-1:WIN_BITS];

  always_comb begin
    kind = RK_NONE;
    if (int'(chan) < NCH) begin
      case (ofs)
        OFS_PRE:  kind = RK_PRE;
        OFS_MOD:  kind = RK_MOD;
        OFS_DUTY: kind = RK_DUTY;
        OFS_EN:   kind = RK_EN;
        default:  kind = RK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_pre,
  input  logic              wr_mod,
  input  logic              wr_duty,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRE_W-1:0]  rb_pre,
  output logic [MOD_W-1:0]  rb_mod,
  output logic [DUTY_W-1:0] rb_duty,
  output logic              rb_en,
  output logic              pwm_o
);

  logic [PRE_W-1:0]  sh_pre_q,   act_pre_q,  act_pre_d;
  logic [MOD_W-1:0]  sh_mod_q,   act_mod_q,  act_mod_d;
  logic [DUTY_W-1:0] sh_duty_q,  act_duty_q, act_duty_d;
  logic              pend_q, pend_d, en_q, en_d;
  logic [PRE_W-1:0]  pcnt_q, pcnt_d;
  logic [MOD_W-1:0]  scnt_q, scnt_d;
  logic              pwm_q, pwm_d;
  logic [MOD_W-1:0]  last_step;
  logic              tick, boundary, commit, start;

  always_comb begin
    last_step = (act_mod_q <= MOD_W'(1)) ? '0 : act_mod_q - MOD_W'(1);
    tick      = en_q && (pcnt_q == act_pre_q);
    boundary  = tick && (scnt_q == last_step);
    commit    = pend_q && (!en_q || boundary);
    en_d      = wr_en ? wdata[0] : en_q;
    start     = en_d && !en_q;
    pend_d    = wr_duty ? 1'b1 : (commit ? 1'b0 : pend_q);

    act_pre_d  = commit ? sh_pre_q  : act_pre_q;
    act_mod_d  = commit ? sh_mod_q  : act_mod_q;
    act_duty_d = commit ? sh_duty_q : act_duty_q;

    pcnt_d = pcnt_q;
    scnt_d = scnt_q;
    if (!en_d || start) begin
      pcnt_d = '0;
      scnt_d = '0;
    end else if (tick) begin
      pcnt_d = '0;
      scnt_d = boundary ? '0 : scnt_q + MOD_W'(1);
    end else begin
      pcnt_d = pcnt_q + PRE_W'(1);
    end

    pwm_d = en_d && (DUTY_W'(scnt_d) < act_duty_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pre_q   <= '0;
      sh_mod_q   <= '0;
      sh_duty_q  <= '0;
      act_pre_q  <= '0;
      act_mod_q  <= '0;
      act_duty_q <= '0;
      pend_q     <= 1'b0;
      en_q       <= 1'b0;
      pcnt_q     <= '0;
      scnt_q     <= '0;
      pwm_q      <= 1'b0;
    end else begin
      if (wr_pre)  sh_pre_q  <= wdata[PRE_W-1:0];
      if (wr_mod)  sh_mod_q  <= wdata[MOD_W-1:0];
      if (wr_duty) sh_duty_q <= wdata[DUTY_W-1:0];
      act_pre_q  <= act_pre_d;
      act_mod_q  <= act_mod_d;
      act_duty_q <= act_duty_d;
      pend_q     <= pend_d;
      en_q       <= en_d;
      pcnt_q     <= pcnt_d;
      scnt_q     <= scnt_d;
      pwm_q      <= pwm_d;
    end
  end

  assign rb_pre  = sh_pre_q;
  assign rb_mod  = sh_mod_q;
  assign rb_duty = sh_duty_q;
  assign rb_en   = en_q;
  assign pwm_o   = pwm_q;

  // R8
  stop_now_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdata[0]) |=> !pwm_o);

  // R5
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> ($stable(act_mod_q) && $stable(act_pre_q) && $stable(act_duty_q)));

  // R6
  boundary_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !boundary) |=> ($stable(act_mod_q) && $stable(act_pre_q) && $stable(act_duty_q)));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (scnt_q <= last_step));

  // R4
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && act_mod_q != '0 && DUTY_W'(act_mod_q) <= act_duty_q) |-> pwm_o);

endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  localparam int CHB   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW    = CHB + WIN_BITS
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);

  logic [CHB-1:0]    chan;
  reg_kind_e         kind;
  logic [PRE_W-1:0]  rb_pre  [NCH];
  logic [MOD_W-1:0]  rb_mod  [NCH];
  logic [DUTY_W-1:0] rb_duty [NCH];
  logic              rb_en   [NCH];
  logic [NCH-1:0]    wr_any;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  mpwm_decode #(.NCH(NCH)) u_dec (
    .addr (bus_addr),
    .chan (chan),
    .kind (kind)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel       = bus_wr && (int'(chan) == g);
    assign wr_any[g] = sel && (kind != RK_NONE);

    mpwm_channel #(
      .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_pre  (sel && kind == RK_PRE),
      .wr_mod  (sel && kind == RK_MOD),
      .wr_duty (sel && kind == RK_DUTY),
      .wr_en   (sel && kind == RK_EN),
      .wdata   (bus_wdata),
      .rb_pre  (rb_pre[g]),
      .rb_mod  (rb_mod[g]),
      .rb_duty (rb_duty[g]),
      .rb_en   (rb_en[g]),
      .pwm_o   (pwm_o[g])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(chan) == i) begin
        case (kind)
          RK_PRE:  rd_val = DATA_W'(rb_pre[i]);
          RK_MOD:  rd_val = DATA_W'(rb_mod[i]);
          RK_DUTY: rd_val = DATA_W'(rb_duty[i]);
          RK_EN:   rd_val = DATA_W'(rb_en[i]);
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;

  // R10
  one_chan_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_any));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && kind == RK_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/mpwm_top_tb.sv
module mpwm_top_tb;

  localparam int NCH = 4;
  localparam int AW  = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] pwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mpwm_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  // vector: {channel, prescaler, modulus, duty}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd0, 8'd4,   8'd2},
    {8'd1, 8'd2, 8'd5,   8'd1},
    {8'd2, 8'd0, 8'd6,   8'd9},
    {8'd3, 8'd1, 8'd3,   8'd0},
    {8'd0, 8'd0, 8'd1,   8'd1},
    {8'd1, 8'd3, 8'd0,   8'd0},
    {8'd2, 8'd0, 8'd255, 8'd128},
    {8'd3, 8'd0, 8'd10,  8'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int ofs, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'((ch << 5) | ofs); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int ofs, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'((ch << 5) | ofs);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R9 reset state
    bad = 0;
    for (int c = 0; c < NCH; c++) begin
      rd(c, 'h00, d); if (d != 0) bad++;
      rd(c, 'h04, d); if (d != 0) bad++;
      rd(c, 'h08, d); if (d != 0) bad++;
      rd(c, 'h18, d); if (d != 0) bad++;
    end
    check(bad == 0, "R9 regs zero", bad, 0);
    check(pwm_o == 0, "R9 lines low", int'(pwm_o), 0);

    // R1 readback with field masks
    wr(2, 'h00, 32'hFFFF_FF5A);
    wr(2, 'h04, 32'h0000_01C3);
    wr(2, 'h08, 32'hFFFF_BEEF);
    rd(2, 'h00, d); check(d == 32'h5A,   "R1 prescaler", int'(d), 'h5A);
    rd(2, 'h04, d); check(d == 32'hC3,   "R1 modulus",   int'(d), 'hC3);
    rd(2, 'h08, d); check(d == 32'hBEEF, "R1 duty",      int'(d), 'hBEEF);
    wr(2, 'h18, 32'hFFFF_FFFF);
    rd(2, 'h18, d); check(d == 32'h1,    "R1 enable",    int'(d), 1);
    wr(2, 'h18, 0);

    // R2 unmapped offset
    wr(2, 'h0C, 32'h1234_5678);
    rd(2, 'h0C, d); check(d == 0, "R2 unmapped read", int'(d), 0);
    rd(2, 'h04, d); check(d == 32'hC3, "R2 no side effect", int'(d), 'hC3);

    // R10 independence: ch0 full high, others low; others' regs untouched
    wr(0, 'h04, 8); wr(0, 'h08, 8); wr(0, 'h18, 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_o != 4'b0001) bad++;
    end
    check(bad == 0, "R10 other lines idle", bad, 0);
    rd(1, 'h08, d); check(d == 0, "R10 ch1 duty untouched", int'(d), 0);
    wr(0, 'h18, 0);

    // R3 R4 R7 vector table, cycle-exact from restart
    foreach (VEC[v]) begin
      int ch, pre, md, du, mef, hi, per;
      ch = int'(VEC[v][31:24]); pre = int'(VEC[v][23:16]);
      md = int'(VEC[v][15:8]);  du  = int'(VEC[v][7:0]);
      mef = (md == 0) ? 1 : md;
      hi  = ((du < mef) ? du : mef) * (pre + 1);
      per = mef * (pre + 1);
      wr(ch, 'h18, 0);
      wr(ch, 'h00, pre); wr(ch, 'h04, md); wr(ch, 'h08, du);
      wr(ch, 'h18, 1);
      bad = 0;
      for (int i = 0; i < 2 * per; i++) begin
        @(negedge clk);
        if (pwm_o[ch] != ((i % per) < hi)) bad++;
      end
      check(bad == 0, "R3/R4/R7 waveform vector", bad, 0);
      wr(ch, 'h18, 0);
    end

    // R5 modulus/prescaler alone do not change the running wave
    begin
      logic s [24];
      int r, olds;
      wr(0, 'h00, 0); wr(0, 'h04, 4); wr(0, 'h08, 1); wr(0, 'h18, 1);
      repeat (5) @(negedge clk);
      wr(0, 'h04, 8);
      wr(0, 'h00, 0);
      bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (pwm_o[0]) bad++;
      end
      check(bad == 2, "R5 highs in 8 cycles", bad, 2);

      // R6 duty write commits at next boundary
      wr(0, 'h08, 6);
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        s[i] = pwm_o[0];
      end
      r = -1;
      for (int i = 1; i < 24; i++) if (r < 0 && s[i] && !s[i-1]) r = i;
      check(r >= 1 && r <= 5, "R6 first new period start", r, 5);
      olds = 0;
      for (int i = 0; i < 24; i++) if (r > 0 && i < r && s[i]) olds++;
      check(olds <= 1, "R6 old tail highs", olds, 1);
      bad = 0;
      if (r > 0) for (int i = 0; i < 16; i++) if (s[r+i] != ((i % 8) < 6)) bad++;
      check(r > 0 && bad == 0, "R6 new period shape", bad, 0);
    end

    // R8 disable mid-period while high
    wr(1, 'h00, 0); wr(1, 'h04, 200); wr(1, 'h08, 250); wr(1, 'h18, 1);
    repeat (10) @(negedge clk);
    check(pwm_o[1] == 1'b1, "R8 line high before stop", int'(pwm_o[1]), 1);
    wr(1, 'h18, 0);
    check(pwm_o[1] == 1'b0, "R8 line low at once", int'(pwm_o[1]), 0);

    // R7 restart from step 0 after re-enable
    wr(1, 'h04, 10); wr(1, 'h08, 3);
    wr(1, 'h18, 1);
    repeat (6) @(negedge clk);
    wr(1, 'h18, 0); wr(1, 'h18, 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_o[1] != ((i % 10) < 3)) bad++;
    end
    check(bad == 0, "R7 restart shape", bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule